// File: doc/BRIEF.md
# Fault Flag and Blanking Controller

This block sits between the current-sense comparators of a half-bridge gate driver and the gate logic. It watches the PWM command, two over-current comparator bits (one across the high-side switch, one on the output current limit) and two supply-health bits (under-voltage and over-temperature). From these it produces a pulse-truncate request for the gate logic and a single fault flag for the system.

Switching noise right after the high-side switch turns on would trip the current comparators falsely, so both comparators are ignored for a programmable number of clock cycles from each PWM rising edge. Once that window is over, any comparator hit during the on-time truncates the rest of the pulse and latches an over-current fault. The latched fault is released only at a PWM falling edge that ends an on-time in which no over-current was seen. Under-voltage and over-temperature bypass the latch: they drive the flag directly for as long as they last.

Top module: `fault_blank_ctrl`

## Requirements
- R1: While and after reset, with all inputs low, `trunc_req` and `fault_flag` are low; reset clears the over-current latch and the blanking counter, and the registered PWM copy resets to low.
- R2: Both comparator inputs are ignored in the clock cycle in which `pwm_in` is first seen high (PWM high, registered copy low) and in the `blank_len` cycles after it, with `blank_len` sampled in that first cycle.
- R3: After the blanking window, a comparator bit high while `pwm_in` is high raises `trunc_req` in the same cycle, and `trunc_req` then stays high until `pwm_in` goes low, even when the comparator drops.
- R4: A qualified hit on either comparator (`hs_oc_raw` or `out_lim_raw`) sets the over-current latch, so `fault_flag` is high from the next cycle on.
- R5: While `pwm_in` is low, both comparator bits have no effect: `trunc_req` stays low and the latch is not set.
- R6: The latched flag clears in the cycle after the one where `pwm_in` is first seen low, but only if no qualified over-current occurred during the on-time that just ended; otherwise it stays set through at least one more on-time.
- R7: An on-time shorter than the blanking window counts as clean, so its falling edge clears the latch even when a comparator was high throughout it.
- R8: `fault_flag` is the OR of the latch with `uv_raw` and `ot_raw`, combinationally: it rises in the same cycle either level bit rises and falls in the same cycle both are low with the latch clear.
- R9: With `blank_len` equal to 0 only the first high cycle is blanked, and a comparator hit in the second high cycle truncates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command, high requests high-side on-time |
| hs_oc_raw | input | 1 | High-side switch over-current comparator |
| out_lim_raw | input | 1 | Output current-limit comparator |
| uv_raw | input | 1 | Under-voltage condition, level |
| ot_raw | input | 1 | Over-temperature condition, level |
| blank_len | input | CNT_W | Blanking cycles after the first high cycle |
| trunc_req | output | 1 | Request to end the current high-side pulse |
| fault_flag | output | 1 | Combined fault indication |

## Verification
A counter that reloads or counts down wrongly shows up as `trunc_req` rising one cycle early or late relative to the first cycle that is clear of blanking, so the bench probes both the last blanked cycle and the first sensed one. A stuck or misupdated on-time history appears at the next falling edge: the flag either drops after a dirty on-time or survives a clean one, visible one cycle after `pwm_in` falls. A latch that fails to set is exposed one cycle after the first truncation, and a wrong level path shows on `fault_flag` in the very cycle `uv_raw` or `ot_raw` changes.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int CNT_W_DEF = 8;

    // PWM view after edge detection
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pwm_evt_t;

    // The two current comparators
    typedef struct packed {
        logic hs_oc;
        logic out_lim;
    } isense_t;

    function automatic logic any_oc(isense_t s);
        return s.hs_oc | s.out_lim;
    endfunction

endpackage

// File: rtl/fbc_edge.sv
module fbc_edge
    import fbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwm,
    output pwm_evt_t evt
);

    logic pwm_q;

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm;
    end

    always_comb begin
        evt.level = pwm;
        evt.rise  = pwm & ~pwm_q;
        evt.fall  = ~pwm & pwm_q;
    end

endmodule

// File: rtl/fbc_blank.sv
module fbc_blank
    import fbc_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  pwm_evt_t         evt,
    input  logic [CNT_W-1:0] len,
    output logic             window
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= ZERO;
        else if (evt.rise)   cnt <= len;
        else if (!evt.level) cnt <= ZERO;
        else if (cnt != ZERO) cnt <= cnt - ONE;
    end

    // first high cycle plus the loaded count
    assign window = evt.rise | (cnt != ZERO);

endmodule

// File: rtl/fbc_oc_track.sv
module fbc_oc_track
    import fbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwm_evt_t evt,
    input  logic     window,
    input  isense_t  sense,
    output logic     trunc,
    output logic     latched
);

    logic oc_hit;
    logic dirty;   // qualified over-current seen in this on-time

    assign oc_hit = evt.level & ~window & any_oc(sense);
    assign trunc  = evt.level & (dirty | oc_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            dirty   <= 1'b0;
            latched <= 1'b0;
        end else begin
            dirty <= evt.level & (dirty | oc_hit);
            if (oc_hit)
                latched <= 1'b1;
            else if (evt.fall && !dirty)
                latched <= 1'b0;
        end
    end

endmodule

// File: rtl/fault_blank_ctrl.sv
module fault_blank_ctrl
    import fbc_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_in,
    input  logic             hs_oc_raw,
    input  logic             out_lim_raw,
    input  logic             uv_raw,
    input  logic             ot_raw,
    input  logic [CNT_W-1:0] blank_len,
    output logic             trunc_req,
    output logic             fault_flag
);

    pwm_evt_t evt;
    isense_t  sense;
    logic     window;
    logic     oc_latched;

    assign sense.hs_oc   = hs_oc_raw;
    assign sense.out_lim = out_lim_raw;

    fbc_edge u_edge (
        .clk (clk),
        .rst (rst),
        .pwm (pwm_in),
        .evt (evt)
    );

    fbc_blank #(.CNT_W(CNT_W)) u_blank (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .len    (blank_len),
        .window (window)
    );

    fbc_oc_track u_track (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .window  (window),
        .sense   (sense),
        .trunc   (trunc_req),
        .latched (oc_latched)
    );

    assign fault_flag = oc_latched | uv_raw | ot_raw;

endmodule

module fault_blank_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic pwm_in,
    input logic uv_raw,
    input logic ot_raw,
    input logic trunc_req,
    input logic fault_flag
);

    logic pwm_d, pwm_dd, flag_d, lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_d  <= 1'b0;
            pwm_dd <= 1'b0;
            flag_d <= 1'b0;
            lvl_d  <= 1'b0;
        end else begin
            pwm_d  <= pwm_in;
            pwm_dd <= pwm_d;
            flag_d <= fault_flag;
            lvl_d  <= uv_raw | ot_raw;
        end
    end

    assert_trunc_in_on_R5: assert property (@(posedge clk) disable iff (rst)
        trunc_req |-> pwm_in);

    assert_first_high_blanked_R2: assert property (@(posedge clk) disable iff (rst)
        (pwm_in && !pwm_d) |-> !trunc_req);

    assert_trunc_holds_R3: assert property (@(posedge clk) disable iff (rst)
        trunc_req |=> (!pwm_in || trunc_req));

    assert_trunc_latches_R4: assert property (@(posedge clk) disable iff (rst)
        trunc_req |=> fault_flag);

    assert_level_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (uv_raw || ot_raw) |-> fault_flag);

    assert_clear_after_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (flag_d && !lvl_d && !fault_flag) |-> (!pwm_d && pwm_dd));

endmodule

bind fault_blank_ctrl fault_blank_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwm_in     (pwm_in),
    .uv_raw     (uv_raw),
    .ot_raw     (ot_raw),
    .trunc_req  (trunc_req),
    .fault_flag (fault_flag)
);

// File: tb/fault_blank_ctrl_test.sv
`timescale 1ns/1ps
module fault_blank_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm_in = 1'b0;
    logic       hs_oc_raw = 1'b0;
    logic       out_lim_raw = 1'b0;
    logic       uv_raw = 1'b0;
    logic       ot_raw = 1'b0;
    logic [7:0] blank_len = 8'd0;
    logic       trunc_req;
    logic       fault_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fault_blank_ctrl #(.CNT_W(8)) uut (
        .clk         (clk),
        .rst         (rst),
        .pwm_in      (pwm_in),
        .hs_oc_raw   (hs_oc_raw),
        .out_lim_raw (out_lim_raw),
        .uv_raw      (uv_raw),
        .ot_raw      (ot_raw),
        .blank_len   (blank_len),
        .trunc_req   (trunc_req),
        .fault_flag  (fault_flag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic p, input logic h, input logic l);
        pwm_in = p; hs_oc_raw = h; out_lim_raw = l;
        #0.5;
    endtask

    task automatic chk(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        repeat (3) tick();
        chk(trunc_req, 1'b0, "R1 trunc in reset");
        chk(fault_flag, 1'b0, "R1 flag in reset");
        rst = 1'b0;
        tick();
        chk(trunc_req, 1'b0, "R1 trunc after reset");
        chk(fault_flag, 1'b0, "R1 flag after reset");
    endtask

    task automatic t_blank_and_dirty();
        blank_len = 8'd3;
        drive(1'b1, 1'b1, 1'b0);
        chk(trunc_req, 1'b0, "R2 first high cycle blanked");
        tick();
        for (int i = 0; i < 3; i++) begin
            chk(trunc_req, 1'b0, "R2 window cycle blanked");
            tick();
        end
        chk(trunc_req, 1'b1, "R3 first sensed cycle truncates");
        chk(fault_flag, 1'b0, "R4 flag not yet latched");
        tick();
        chk(fault_flag, 1'b1, "R4 flag latched next cycle");
        drive(1'b1, 1'b0, 1'b0);
        chk(trunc_req, 1'b1, "R3 trunc held after comparator drops");
        tick();
        drive(1'b0, 1'b0, 1'b0);
        chk(trunc_req, 1'b0, "R3 trunc ends with on-time");
        tick();
        chk(fault_flag, 1'b1, "R6 dirty on-time keeps flag");
        tick();
        drive(1'b1, 1'b0, 1'b0);
        repeat (6) tick();
        chk(fault_flag, 1'b1, "R6 flag held during clean on-time");
        drive(1'b0, 1'b0, 1'b0);
        chk(fault_flag, 1'b1, "R6 flag held in falling cycle");
        tick();
        chk(fault_flag, 1'b0, "R6 clean on-time clears flag");
        tick();
    endtask

    task automatic t_limit_then_short();
        blank_len = 8'd2;
        drive(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            chk(trunc_req, 1'b0, "R2 limit comparator blanked");
            tick();
        end
        chk(trunc_req, 1'b1, "R4 limit comparator truncates");
        tick();
        chk(fault_flag, 1'b1, "R4 limit comparator latches");
        drive(1'b0, 1'b0, 1'b0);
        tick();
        tick();
        drive(1'b1, 1'b1, 1'b1);
        chk(trunc_req, 1'b0, "R7 short on-time cycle 0");
        tick();
        chk(trunc_req, 1'b0, "R7 short on-time cycle 1");
        tick();
        drive(1'b0, 1'b1, 1'b1);
        tick();
        chk(fault_flag, 1'b0, "R7 short on-time is clean");
        drive(1'b0, 1'b0, 1'b0);
        tick();
    endtask

    task automatic t_pwm_low();
        drive(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            chk(trunc_req, 1'b0, "R5 no trunc while PWM low");
            tick();
        end
        chk(fault_flag, 1'b0, "R5 no latch while PWM low");
        drive(1'b0, 1'b0, 1'b0);
        tick();
    endtask

    task automatic t_zero_blank();
        blank_len = 8'd0;
        drive(1'b1, 1'b1, 1'b0);
        chk(trunc_req, 1'b0, "R9 first high cycle still blanked");
        tick();
        chk(trunc_req, 1'b1, "R9 second high cycle senses");
        tick();
        chk(fault_flag, 1'b1, "R9 zero blank latches");
        drive(1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b1, 1'b0, 1'b0);
        tick();
        drive(1'b0, 1'b0, 1'b0);
        tick();
        chk(fault_flag, 1'b0, "R6 clean one-cycle on-time clears");
    endtask

    task automatic t_levels();
        uv_raw = 1'b1; #0.5;
        chk(fault_flag, 1'b1, "R8 under-voltage raises flag");
        tick();
        uv_raw = 1'b0; #0.5;
        chk(fault_flag, 1'b0, "R8 under-voltage gone clears flag");
        ot_raw = 1'b1; #0.5;
        chk(fault_flag, 1'b1, "R8 over-temperature raises flag");
        tick();
        chk(trunc_req, 1'b0, "R8 level fault does not truncate");
        ot_raw = 1'b0; #0.5;
        chk(fault_flag, 1'b0, "R8 over-temperature gone clears flag");
        tick();
    endtask

    initial begin
        t_reset();
        t_blank_and_dirty();
        t_limit_then_short();
        t_pwm_low();
        t_zero_blank();
        t_levels();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule